// File: doc/BRIEF.md
# Serial Memory Command Controller

This block is a serial-peripheral slave that sits in front of a 2048-byte memory. An external host selects it with an active-low chip select. The host sends an 8-bit command, then a 16-bit address where the command needs one, and then data. All fields travel most significant bit first. The controller reads the array as a continuous stream. It collects writes of up to one 32-byte page and commits them in a self-timed busy window whose length is a parameter.

An 8-bit status byte holds the following fields:

- a pin-gated lock enable
- a software flag
- two watchdog-select bits, stored for a neighbour
- two block-lock bits
- the write-enable latch
- a busy bit

The block-lock bits protect the top quarter, the top half or the whole array against writes. The lock enable, together with a low level on the write-protect pin, freezes the status byte.

The serial pins are asynchronous to the system clock. They are synchronised inside the block, so the serial clock must run several times slower than the system clock.

Top module: `spi_mem_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output enable is low.
- R2: Serial modes 0 and 3 both work. Input is taken on the rising serial-clock edge and output changes on the falling edge, MSB first. `so_oe` is low while chip select is high and outside a read or status-read output phase.
- R3: Command 0x06 sets the write-enable latch and 0x00 sets the flag. Command 0x04 clears both. Each of these acts only when chip select rises directly after the eighth command bit; with any extra clock the command is dropped.
- R4: Status byte bit positions are 7 lock enable, 6 flag, 5:4 watchdog select, 3:2 block lock, 1 write-enable latch, 0 busy. Command 0x05 streams the status byte. Command 0x01 with one data byte updates bits 7:2 only; data bits 1:0 are ignored.
- R5: Command 0x03 plus a 16-bit address (bits 15:11 ignored) streams bytes from incrementing addresses, wrapping from 0x7FF to 0x000.
- R6: Command 0x02 plus a 16-bit address collects data bytes. The address wraps inside its 32-byte page, so later bytes overwrite earlier ones.
- R7: A data write (0x02) or status write (0x01) is committed only if chip select rises on a byte boundary after at least one data byte. Otherwise it is discarded, busy stays 0 and the write-enable latch is kept.
- R8: A committed write sets busy for BUSY_CYCLES clocks. Busy and the latch read as 1 during the window; the latch is cleared when the window ends.
- R9: While busy is 1, every command other than status read (0x05) is ignored, and the output stays disabled for them.
- R10: Block-lock code 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF and 11 protects the whole array; 00 protects nothing. Protected bytes keep their contents and remain readable, while unprotected bytes of the same write are stored.
- R11: With the write-protect pin low and the lock enable set, status writes are refused. A status write already committed still completes if the pin drops afterwards.
- R12: A data write or status write without the write-enable latch set has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |

## Verification
The assertions assume a well-behaved host. Chip select and serial-clock edges never fall in the same synchronised sample. The host starts no new frame within one clock of the end of the previous one, and it uses only one bus. Under these rules no frame can be in progress when busy rises.

The bench keeps within these rules by driving each serial-clock half period for six system clocks. It also leaves a gap of twelve clocks around every chip-select transition. All frames come from one sequential initial block.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_FLG_SET = 8'h00;
  localparam logic [7:0] OP_CLR     = 8'h04;
  localparam logic [7:0] OP_ST_RD   = 8'h05;
  localparam logic [7:0] OP_ST_WR   = 8'h01;
  localparam logic [7:0] OP_ARR_RD  = 8'h03;
  localparam logic [7:0] OP_ARR_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_OUT, PH_WDATA, PH_SDATA, PH_HOLD, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {HC_NONE, HC_WEL, HC_FLAG, HC_CLR} hold_t;

  // top: the two most significant address bits (quarter of the array)
  function automatic logic quarter_locked(input logic [1:0] bl, input logic [1:0] top);
    case (bl)
      2'b00:   return 1'b0;
      2'b01:   return top == 2'b11;
      2'b10:   return top[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_wcycle.sv
module spi_mem_wcycle #(
  parameter int BUSY_CYCLES = 250000,
  parameter int PW          = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          c_en,
  output logic [PW-1:0] c_idx,
  output logic          done
);
  localparam int PAGE = 1 << PW;
  localparam int CW   = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign done  = busy && (cnt == LAST);
  assign c_en  = busy && (32'(cnt) < PAGE);
  assign c_idx = cnt[PW-1:0];

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) busy |-> cnt <= LAST);
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int AW          = 11,
  parameter int PW          = 5,
  parameter int BUSY_CYCLES = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int PAGE = 1 << PW;
  localparam int PGW  = AW - PW;

  // ---------------- pin synchronisation and edges
  logic [3:0] pin_q;
  logic       sck_d, csn_d;

  spi_pin_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({wp_n, si, cs_n, sck}), .q(pin_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      csn_d <= 1'b0;
    end else begin
      sck_d <= pin_q[0];
      csn_d <= pin_q[1];
    end
  end

  logic sck_r, sck_f, cs_fall, cs_rise, sel, si_s, wp_s;
  assign sck_r   = pin_q[0] & ~sck_d;
  assign sck_f   = ~pin_q[0] & sck_d;
  assign cs_fall = ~pin_q[1] & csn_d;
  assign cs_rise = pin_q[1] & ~csn_d;
  assign sel     = ~pin_q[1];
  assign si_s    = pin_q[2];
  assign wp_s    = pin_q[3];

  // ---------------- state
  phase_t          phase;
  hold_t           hold;
  logic [3:0]      bcnt;
  logic [6:0]      shreg;
  logic [AW-2:0]   acc;
  logic            is_rd, got;
  logic [PW-1:0]   wptr;
  logic [PGW-1:0]  page;
  logic [PAGE-1:0] mask;
  logic [7:2]      sr_new;
  logic [AW-1:0]   rd_ptr;
  logic [2:0]      obit;
  logic [6:0]      txs;
  logic            src_stat, so_q, oe_q;
  logic            wpen, flb, wel;
  logic [1:0]      wd, bl;
  logic            start_q, start_arr_q, cyc_arr;
  logic [7:0]      pbuf [PAGE];

  logic            wip, c_en, done;
  logic [PW-1:0]   c_idx;
  logic [7:0]      ram_q;
  logic            ram_we;

  logic [7:0]      byte_in, stat_byte;
  logic [AW-1:0]   adr_in;
  logic            sck_active, byte_end;

  assign byte_in    = {shreg, si_s};
  assign adr_in     = {acc, si_s};
  assign stat_byte  = {wpen, flb, wd, bl, wel, wip};
  assign sck_active = sel && !cs_fall && !cs_rise;
  assign byte_end   = bcnt[2:0] == 3'd7;

  // ---------------- self-timed cycle
  spi_mem_wcycle #(.BUSY_CYCLES(BUSY_CYCLES), .PW(PW)) u_cyc (
    .clk(clk), .rst(rst), .start(start_q), .busy(wip),
    .c_en(c_en), .c_idx(c_idx), .done(done)
  );

  // ---------------- array and commit path
  assign ram_we = cyc_arr && c_en && mask[c_idx] &&
                  !quarter_locked(bl, page[PGW-1 -: 2]);

  spi_mem_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr({page, c_idx}), .wdata(pbuf[c_idx]),
    .raddr(rd_ptr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (sck_active && sck_r && phase == PH_WDATA && byte_end)
      pbuf[wptr] <= byte_in;
  end

  // ---------------- command engine
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;  hold <= HC_NONE;  bcnt <= '0;  shreg <= '0;
      acc <= '0;  is_rd <= 1'b0;  got <= 1'b0;  wptr <= '0;  page <= '0;
      mask <= '0;  sr_new <= '0;  rd_ptr <= '0;  obit <= '0;  txs <= '0;
      src_stat <= 1'b0;  so_q <= 1'b0;  oe_q <= 1'b0;
      wpen <= 1'b0;  flb <= 1'b0;  wel <= 1'b0;  wd <= '0;  bl <= '0;
      start_q <= 1'b0;  start_arr_q <= 1'b0;  cyc_arr <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (start_q) cyc_arr <= start_arr_q;

      if (cs_fall) begin
        phase <= PH_OPC;
        bcnt  <= '0;
        got   <= 1'b0;
      end else if (cs_rise) begin
        phase <= PH_IDLE;
        oe_q  <= 1'b0;
        case (phase)
          PH_HOLD: begin
            case (hold)
              HC_WEL:  wel <= 1'b1;
              HC_FLAG: flb <= 1'b1;
              HC_CLR:  begin wel <= 1'b0; flb <= 1'b0; end
              default: ;
            endcase
          end
          PH_WDATA: begin
            if (got && bcnt[2:0] == 3'd0 && wel) begin
              start_q     <= 1'b1;
              start_arr_q <= 1'b1;
            end
          end
          PH_SDATA: begin
            if (got && bcnt[2:0] == 3'd0 && wel && !(wpen && !wp_s)) begin
              start_q     <= 1'b1;
              start_arr_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (sel) begin
        if (sck_r) begin
          shreg <= byte_in[6:0];
          case (phase)
            PH_OPC: begin
              bcnt <= bcnt + 1'b1;
              if (byte_end) begin
                bcnt <= '0;
                if (wip && byte_in != OP_ST_RD) phase <= PH_SKIP;
                else begin
                  case (byte_in)
                    OP_WEL_SET: begin phase <= PH_HOLD; hold <= HC_WEL;  end
                    OP_FLG_SET: begin phase <= PH_HOLD; hold <= HC_FLAG; end
                    OP_CLR:     begin phase <= PH_HOLD; hold <= HC_CLR;  end
                    OP_ST_RD: begin
                      phase <= PH_OUT;  src_stat <= 1'b1;
                      obit  <= '0;      oe_q     <= 1'b1;
                    end
                    OP_ST_WR:  phase <= PH_SDATA;
                    OP_ARR_RD: begin phase <= PH_ADDR; is_rd <= 1'b1; end
                    OP_ARR_WR: begin phase <= PH_ADDR; is_rd <= 1'b0; end
                    default:   phase <= PH_SKIP;
                  endcase
                end
              end
            end
            PH_ADDR: begin
              bcnt <= bcnt + 1'b1;
              acc  <= adr_in[AW-2:0];
              if (bcnt == 4'd15) begin
                if (is_rd) begin
                  phase  <= PH_OUT;  src_stat <= 1'b0;
                  rd_ptr <= adr_in;  obit     <= '0;
                  oe_q   <= 1'b1;
                end else begin
                  phase <= PH_WDATA;
                  wptr  <= adr_in[PW-1:0];
                  page  <= adr_in[AW-1:PW];
                  mask  <= '0;
                end
              end
            end
            PH_WDATA: begin
              bcnt <= bcnt + 1'b1;
              if (byte_end) begin
                mask[wptr] <= 1'b1;
                wptr       <= wptr + 1'b1;
                got        <= 1'b1;
              end
            end
            PH_SDATA: begin
              if (got) phase <= PH_SKIP;
              else begin
                bcnt <= bcnt + 1'b1;
                if (byte_end) begin
                  sr_new <= byte_in[7:2];
                  got    <= 1'b1;
                end
              end
            end
            PH_HOLD: phase <= PH_SKIP;
            default: ;
          endcase
        end

        if (sck_f && phase == PH_OUT) begin
          obit <= obit + 1'b1;
          if (obit == 3'd0) begin
            so_q <= src_stat ? stat_byte[7] : ram_q[7];
            txs  <= src_stat ? stat_byte[6:0] : ram_q[6:0];
            if (!src_stat) rd_ptr <= rd_ptr + 1'b1;
          end else begin
            so_q <= txs[6];
            txs  <= {txs[5:0], 1'b0};
          end
        end
      end

      if (done) begin
        wel <= 1'b0;
        if (!cyc_arr) begin
          wpen <= sr_new[7];
          flb  <= sr_new[6];
          wd   <= sr_new[5:4];
          bl   <= sr_new[3:2];
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (rst) cs_rise |=> !so_oe);
  // R12
  wel_we_chk: assert property (@(posedge clk) disable iff (rst) ram_we |-> wel);
  // R8
  wel_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(wip) |-> !wel);
  // R11
  wp_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wpen && !wp_s && !wip) |=> $stable({wpen, wd, bl}));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) wip |-> phase != PH_HOLD);
  // R9
  busy_out_chk: assert property (@(posedge clk) disable iff (rst)
    (wip && phase == PH_OUT) |-> src_stat);
endmodule

// File: tb/tb_spi_mem_ctrl.sv
module tb_spi_mem_ctrl;
  localparam int BUSY = 1000;
  localparam int HP   = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;

  int total = 0, bad = 0;
  logic [7:0] txb [64];
  logic [7:0] rxb [64];
  logic       oe_seen;

  always #10 clk = ~clk;

  spi_mem_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr_tx();
    for (int i = 0; i < 64; i++) txb[i] = 8'h00;
  endtask

  task automatic frame(input int nbytes, input int extra, input bit m3);
    int nb;
    nb = nbytes * 8 + extra;
    oe_seen = 1'b0;
    @(negedge clk); sck = m3;
    repeat (HP) @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0;
      si  = txb[i/8][7 - (i % 8)];
      repeat (HP) @(negedge clk);
      rxb[i/8][7 - (i % 8)] = so;
      oe_seen = oe_seen | so_oe;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
    end
    if (!m3) sck = 1'b0;
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op, input int extra);
    clr_tx(); txb[0] = op; frame(1, extra, 1'b0);
  endtask

  task automatic rdsr(output logic [7:0] s, input bit m3);
    clr_tx(); txb[0] = 8'h05; frame(2, 0, m3); s = rxb[1];
  endtask

  task automatic wrsr(input logic [7:0] v);
    clr_tx(); txb[0] = 8'h01; txb[1] = v; frame(2, 0, 1'b0);
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] d, input int extra);
    clr_tx(); txb[0] = 8'h02; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = d;
    frame(4, extra, 1'b0);
  endtask

  task automatic read_n(input logic [15:0] a, input int n, input bit m3);
    clr_tx(); txb[0] = 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0];
    frame(3 + n, 0, m3);
  endtask

  task automatic wait_cycle();
    repeat (BUSY + 50) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 oe after reset", int'(so_oe), 0);
    rdsr(s, 1'b0);
    chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd(8'h06, 0); rdsr(s, 1'b0);
    chk("R3 wel set", s, 8'h02);
    cmd(8'h00, 0); rdsr(s, 1'b1);
    chk("R3 R2 flag set mode3", s, 8'h42);
    cmd(8'h04, 0); rdsr(s, 1'b0);
    chk("R3 clear both", s, 8'h00);
    cmd(8'h06, 1); rdsr(s, 1'b0);
    chk("R3 extra clock drops", s, 8'h00);
  endtask

  task automatic t_page();
    logic [7:0] s;
    cmd(8'h06, 0);
    clr_tx(); txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h10;
    txb[3] = 8'h11; txb[4] = 8'h22; txb[5] = 8'h33;
    frame(6, 0, 1'b0);
    rdsr(s, 1'b0);
    chk("R8 busy and wel", s, 8'h03);
    wait_cycle();
    rdsr(s, 1'b0);
    chk("R8 wel cleared", s, 8'h00);
    read_n(16'h0010, 3, 1'b1);
    chk("R5 R2 byte0", rxb[3], 8'h11);
    chk("R5 byte1", rxb[4], 8'h22);
    chk("R5 byte2", rxb[5], 8'h33);
  endtask

  task automatic t_wrap_page();
    cmd(8'h06, 0);
    clr_tx(); txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h3E;
    for (int i = 0; i < 4; i++) txb[3+i] = 8'hA0 + 8'(i);
    frame(7, 0, 1'b0);
    wait_cycle();
    read_n(16'h0020, 2, 1'b0);
    chk("R6 wrap 0x20", rxb[3], 8'hA2);
    chk("R6 wrap 0x21", rxb[4], 8'hA3);
    read_n(16'h003E, 2, 1'b0);
    chk("R6 0x3E", rxb[3], 8'hA0);
    chk("R6 0x3F", rxb[4], 8'hA1);
  endtask

  task automatic t_nowel();
    logic [7:0] s;
    write1(16'h0010, 8'h99, 0);
    rdsr(s, 1'b0);
    chk("R12 no busy", s, 8'h00);
    read_n(16'h0010, 1, 1'b0);
    chk("R12 data kept", rxb[3], 8'h11);
  endtask

  task automatic t_misalign();
    logic [7:0] s;
    cmd(8'h06, 0);
    write1(16'h0010, 8'h77, 3);
    rdsr(s, 1'b0);
    chk("R7 misaligned no busy", s, 8'h02);
    clr_tx(); txb[0] = 8'h02; txb[2] = 8'h10; frame(3, 0, 1'b0);
    rdsr(s, 1'b0);
    chk("R7 no data byte", s, 8'h02);
    read_n(16'h0010, 1, 1'b0);
    chk("R7 data kept", rxb[3], 8'h11);
    cmd(8'h04, 0);
  endtask

  task automatic t_readwrap();
    cmd(8'h06, 0); write1(16'h07FF, 8'h5A, 0); wait_cycle();
    cmd(8'h06, 0); write1(16'h0000, 8'hC3, 0); wait_cycle();
    read_n(16'h07FF, 2, 1'b0);
    chk("R5 top", rxb[3], 8'h5A);
    chk("R5 wrap to 0", rxb[4], 8'hC3);
    read_n(16'hFFFF, 1, 1'b1);
    chk("R5 upper addr bits ignored", rxb[3], 8'h5A);
  endtask

  task automatic t_status_lock();
    logic [7:0] s;
    cmd(8'h06, 0); write1(16'h0400, 8'hD0, 0); wait_cycle();
    cmd(8'h06, 0); write1(16'h0600, 8'hD1, 0); wait_cycle();
    cmd(8'h06, 0); write1(16'h05FF, 8'hD2, 0); wait_cycle();
    cmd(8'h06, 0); wrsr(8'h3B); wait_cycle();
    rdsr(s, 1'b0);
    chk("R4 status write low bits ignored", s, 8'h38);
    wrsr(8'h00);
    rdsr(s, 1'b0);
    chk("R12 status write without wel", s, 8'h38);
    cmd(8'h06, 0); write1(16'h0400, 8'hE2, 0);
    rdsr(s, 1'b0);
    chk("R10 locked write still busy", s, 8'h3B);
    wait_cycle();
    read_n(16'h0400, 1, 1'b0);
    chk("R10 half lock 0x400", rxb[3], 8'hD0);
    cmd(8'h06, 0); write1(16'h03FF, 8'hE1, 0); wait_cycle();
    read_n(16'h03FF, 1, 1'b0);
    chk("R10 half lock 0x3FF open", rxb[3], 8'hE1);
    cmd(8'h06, 0); wrsr(8'h04); wait_cycle();
    cmd(8'h06, 0); write1(16'h05FF, 8'hE3, 0); wait_cycle();
    cmd(8'h06, 0); write1(16'h0600, 8'hE4, 0); wait_cycle();
    read_n(16'h05FF, 2, 1'b0);
    chk("R10 quarter lock 0x5FF open", rxb[3], 8'hE3);
    chk("R10 quarter lock 0x600", rxb[4], 8'hD1);
    cmd(8'h06, 0); wrsr(8'h0C); wait_cycle();
    cmd(8'h06, 0); write1(16'h0000, 8'hE5, 0); wait_cycle();
    read_n(16'h0000, 1, 1'b0);
    chk("R10 full lock", rxb[3], 8'hC3);
    cmd(8'h06, 0); wrsr(8'h00); wait_cycle();
    rdsr(s, 1'b0);
    chk("R4 status cleared", s, 8'h00);
  endtask

  task automatic t_wp();
    logic [7:0] s;
    cmd(8'h06, 0); wrsr(8'h80); wait_cycle();
    wp_n = 1'b0;
    cmd(8'h06, 0); wrsr(8'h00);
    rdsr(s, 1'b0);
    chk("R11 refused", s, 8'h82);
    wp_n = 1'b1;
    wrsr(8'h84);
    wp_n = 1'b0;
    wait_cycle();
    rdsr(s, 1'b0);
    chk("R11 in-flight completes", s, 8'h84);
    wp_n = 1'b1;
    cmd(8'h06, 0); wrsr(8'h00); wait_cycle();
    rdsr(s, 1'b0);
    chk("R11 pin high allows", s, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    cmd(8'h06, 0); write1(16'h0020, 8'hB7, 0);
    cmd(8'h00, 0);
    read_n(16'h0010, 2, 1'b0);
    chk("R9 R2 read ignored oe", int'(oe_seen), 0);
    rdsr(s, 1'b0);
    chk("R9 status readable busy", s, 8'h03);
    wait_cycle();
    rdsr(s, 1'b0);
    chk("R9 flag cmd ignored", s, 8'h00);
    read_n(16'h0020, 1, 1'b0);
    chk("R9 write landed", rxb[3], 8'hB7);
    chk("R2 oe low when idle", int'(so_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_page();
    t_wrap_page();
    t_nowel();
    t_misalign();
    t_readwrap();
    t_status_lock();
    t_wp();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule